// File: doc/BRIEF.md
# Test-Bit Sample Correlation Detector

This block decides whether a single test bit agrees with enough bits of a small group of samples. A caller presents the test bit, five sample lines and a 3-bit threshold code, and pulses a strobe. One clock later the block gives a registered agreement flag and a one-cycle valid pulse. The threshold code selects how many sample lines take part (five, four or three) and how many of them must equal the test bit.

Every threshold is built from 5-input majority cells. Each cell's output is the majority of its inputs XNOR a polarity control. The first-level cells take the test bit as their polarity control, so a cell reads "three or more inputs equal the test bit". Unused cell inputs are filled with the test bit, which counts as a match, or with its complement, which counts as a mismatch. A final majority cell, with two inputs tied low, ANDs the first-level results. No match counter is built anywhere.

Top module: `corr_detect`

## Requirements
- R1: While `rst` is high at a clock edge, `corr_flag` and `corr_valid` are 0 after that edge.
- R2: Code 0: the flag is 1 when at least 3 of `samples[4:0]` equal `test_bit`.
- R3: Code 1: the flag is 1 when at least 4 of `samples[4:0]` equal `test_bit`.
- R4: Code 2: the flag is 1 only when all 5 of `samples[4:0]` equal `test_bit`.
- R5: Code 3: the flag is 1 when at least 3 of `samples[3:0]` equal `test_bit`. `samples[4]` has no effect.
- R6: Code 4: the flag is 1 only when all of `samples[3:0]` equal `test_bit`. `samples[4]` has no effect.
- R7: Code 5: the flag is 1 only when all of `samples[2:0]` equal `test_bit`. `samples[4:3]` have no effect.
- R8: Codes 6 and 7 give a flag of 0 whatever the other inputs are.
- R9: A high `smp_valid` at a clock edge puts the result on `corr_flag`, and sets `corr_valid` to 1 for exactly the following cycle. With `smp_valid` low, `corr_valid` is 0 after the edge.
- R10: With `smp_valid` low, `corr_flag` keeps its value whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: capture a result at this edge |
| test_bit | input | 1 | Bit the samples are compared against |
| samples | input | 5 | Sample bits, index 0 to 4 |
| mode | input | 3 | Threshold code 0 to 5; 6 and 7 are invalid |
| corr_flag | output | 1 | Registered agreement result |
| corr_valid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The block has only one state bit for data. A wrong leg routing or a wrong polarity in a majority cell therefore shows up as a wrong `corr_flag` on the very next strobe for the affected input patterns. The bench tries all 64 test-bit and sample patterns in each of the 8 codes to expose it. A broken capture enable shows as a flag that moves, or a valid pulse that appears, in a cycle without a strobe. This is visible one edge after the missing or extra strobe.

// File: rtl/corr_pkg.sv
package corr_pkg;
    localparam int SAMPLE_W = 5;
    localparam int MODE_W   = 3;
    localparam int MAJ_W    = 5;
    localparam int N_LEGS   = 3;
    localparam int MAJ_HALF = (MAJ_W + 1) / 2;

    typedef enum logic [MODE_W-1:0] {
        THR_5_GE3 = 3'd0,
        THR_5_GE4 = 3'd1,
        THR_5_ALL = 3'd2,
        THR_4_GE3 = 3'd3,
        THR_4_ALL = 3'd4,
        THR_3_ALL = 3'd5
    } thr_code_e;

    typedef logic [MAJ_W-1:0] maj_vec_t;

    typedef struct packed {
        maj_vec_t [N_LEGS-1:0] leg;
        logic                  code_ok;
    } leg_plan_t;

    function automatic logic majority(input maj_vec_t v);
        int ones;
        ones = 0;
        for (int i = 0; i < MAJ_W; i++) begin
            ones += int'(v[i]);
        end
        return ones >= MAJ_HALF;
    endfunction
endpackage

// File: rtl/corr_maj_cell.sv
module corr_maj_cell
    import corr_pkg::*;
(
    input  maj_vec_t legs,
    input  logic     polarity,
    output logic     z
);
    always_comb begin
        z = majority(legs) ~^ polarity;
    end
endmodule

// File: rtl/corr_leg_router.sv
module corr_leg_router
    import corr_pkg::*;
(
    input  logic                test_bit,
    input  logic [SAMPLE_W-1:0] samples,
    input  logic [MODE_W-1:0]   mode,
    output leg_plan_t           plan
);
    logic t, n;
    maj_vec_t all_t;

    always_comb begin
        t     = test_bit;
        n     = ~test_bit;
        all_t = {MAJ_W{test_bit}};
        plan.code_ok = 1'b1;
        plan.leg[0]  = all_t;
        plan.leg[1]  = all_t;
        plan.leg[2]  = all_t;
        case (mode)
            THR_5_GE3: begin
                plan.leg[0] = samples;
            end
            THR_5_GE4: begin
                plan.leg[0] = {n, samples[4], samples[3], samples[2], samples[1]};
                plan.leg[1] = {n, samples[4], samples[3], samples[2], samples[0]};
                plan.leg[2] = {n, samples[4], samples[3], samples[1], samples[0]};
            end
            THR_5_ALL: begin
                plan.leg[0] = {n, n, samples[2], samples[1], samples[0]};
                plan.leg[1] = {n, n, t, samples[4], samples[3]};
            end
            THR_4_GE3: begin
                plan.leg[0] = {n, samples[3], samples[2], samples[1], samples[0]};
            end
            THR_4_ALL: begin
                plan.leg[0] = {n, n, samples[2], samples[1], samples[0]};
                plan.leg[1] = {n, n, t, t, samples[3]};
            end
            THR_3_ALL: begin
                plan.leg[0] = {n, n, samples[2], samples[1], samples[0]};
            end
            default: begin
                plan.code_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/corr_detect.sv
module corr_detect
    import corr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                test_bit,
    input  logic [SAMPLE_W-1:0] samples,
    input  logic [MODE_W-1:0]   mode,
    output logic                corr_flag,
    output logic                corr_valid
);
    leg_plan_t           plan;
    logic [N_LEGS-1:0]   leg_hit;
    maj_vec_t            join_vec;
    logic                join_z;

    corr_leg_router u_router (
        .test_bit (test_bit),
        .samples  (samples),
        .mode     (mode),
        .plan     (plan)
    );

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        corr_maj_cell u_cell (
            .legs     (plan.leg[g]),
            .polarity (test_bit),
            .z        (leg_hit[g])
        );
    end

    // Final cell: two inputs tied low turn the majority into AND3;
    // an invalid code drives every input low.
    always_comb begin
        join_vec = '0;
        if (plan.code_ok) begin
            join_vec[N_LEGS-1:0] = leg_hit;
        end
    end

    corr_maj_cell u_join (
        .legs     (join_vec),
        .polarity (1'b1),
        .z        (join_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_flag  <= 1'b0;
            corr_valid <= 1'b0;
        end else begin
            corr_valid <= smp_valid;
            if (smp_valid) begin
                corr_flag <= join_z;
            end
        end
    end
endmodule

// File: rtl/corr_detect_chk.sv
module corr_detect_chk
    import corr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic                test_bit,
    input logic [SAMPLE_W-1:0] samples,
    input logic [MODE_W-1:0]   mode,
    input logic                corr_flag,
    input logic                corr_valid
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!corr_flag && !corr_valid));

    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> corr_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !corr_valid);

    a_r10_hold_flag: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(corr_flag));

    a_r8_bad_code: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode > 3'd5) |=> !corr_flag);

    a_r2_three_of_five: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == 3'd0 && $countones(samples ^ {SAMPLE_W{test_bit}}) <= 2)
        |=> corr_flag);

    a_r4_all_five: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == 3'd2 && samples != {SAMPLE_W{test_bit}}) |=> !corr_flag);

    a_r7_all_three: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == 3'd5 && samples[2:0] != {3{test_bit}}) |=> !corr_flag);
endmodule

bind corr_detect corr_detect_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .test_bit   (test_bit),
    .samples    (samples),
    .mode       (mode),
    .corr_flag  (corr_flag),
    .corr_valid (corr_valid)
);

// File: tb/corr_detect_test.sv
module corr_detect_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       smp_valid;
    logic       test_bit;
    logic [4:0] samples;
    logic [2:0] mode;
    logic       corr_flag;
    logic       corr_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    corr_detect uut (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .test_bit   (test_bit),
        .samples    (samples),
        .mode       (mode),
        .corr_flag  (corr_flag),
        .corr_valid (corr_valid)
    );

    // {mode, test_bit, samples, expected}
    localparam int NVEC = 13;
    localparam logic [9:0] VEC [NVEC] = '{
        {3'd0, 1'b1, 5'b11100, 1'b1},
        {3'd0, 1'b1, 5'b11000, 1'b0},
        {3'd0, 1'b0, 5'b00011, 1'b1},
        {3'd1, 1'b1, 5'b11110, 1'b1},
        {3'd1, 1'b1, 5'b11100, 1'b0},
        {3'd2, 1'b0, 5'b00000, 1'b1},
        {3'd2, 1'b0, 5'b00001, 1'b0},
        {3'd3, 1'b1, 5'b00111, 1'b1},
        {3'd4, 1'b1, 5'b01111, 1'b1},
        {3'd4, 1'b1, 5'b10111, 1'b0},
        {3'd5, 1'b0, 5'b11000, 1'b1},
        {3'd6, 1'b1, 5'b11111, 1'b0},
        {3'd7, 1'b0, 5'b00000, 1'b0}
    };

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic model(input logic [2:0] m, input logic t, input logic [4:0] s);
        int used, need, hits;
        case (m)
            3'd0: begin used = 5; need = 3; end
            3'd1: begin used = 5; need = 4; end
            3'd2: begin used = 5; need = 5; end
            3'd3: begin used = 4; need = 3; end
            3'd4: begin used = 4; need = 4; end
            3'd5: begin used = 3; need = 3; end
            default: return 1'b0;
        endcase
        hits = 0;
        for (int i = 0; i < used; i++) if (s[i] == t) hits++;
        return hits >= need;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (mode %0d t %b s %b)",
                     req, act, exp, mode, test_bit, samples);
        end
    endtask

    // Drive at negedge with strobe; result is visible at the following negedge.
    task automatic apply(input logic [2:0] m, input logic t, input logic [4:0] s);
        @(negedge clk);
        mode = m; test_bit = t; samples = s; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; test_bit = 1'b0; samples = '0; mode = '0;
        repeat (3) @(negedge clk);
        check("R1", corr_flag, 1'b0);
        check("R1", corr_valid, 1'b0);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            apply(VEC[k][9:7], VEC[k][6], VEC[k][5:1]);
            check(req_of(VEC[k][9:7]), corr_flag, VEC[k][0]);
            check("R9", corr_valid, 1'b1);
        end

        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 64; p++) begin
                apply(3'(m), p[5], p[4:0]);
                check(req_of(3'(m)), corr_flag, model(3'(m), p[5], p[4:0]));
            end
        end

        // R9: pulse lasts one cycle only
        apply(3'd0, 1'b1, 5'b11111);
        check("R9", corr_valid, 1'b1);
        @(negedge clk);
        check("R9", corr_valid, 1'b0);

        // R10: flag holds with strobe low while data changes
        check("R10", corr_flag, 1'b1);
        mode = 3'd0; test_bit = 1'b0; samples = 5'b11111;
        repeat (2) @(negedge clk);
        check("R10", corr_flag, 1'b1);
        check("R10", corr_valid, 1'b0);

        // R1: reset clears a set flag
        rst = 1'b1;
        @(negedge clk);
        check("R1", corr_flag, 1'b0);
        rst = 1'b0;

        // R5/R6/R7: ignored lines flipped change nothing
        apply(3'd3, 1'b0, 5'b10001);
        check("R5", corr_flag, 1'b1);
        apply(3'd6, 1'b0, 5'b00000);
        check("R8", corr_flag, 1'b0);
        apply(3'd5, 1'b1, 5'b00111);
        check("R7", corr_flag, 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule